// File: doc/BRIEF.md
# PWM Time-Base Counter with Phase Synchronisation

This block is the time base of one PWM channel. It holds a counter, 16 bits wide by default, that runs up, down, or up and then down against a programmed period. It flags the cycles in which the counter sits at zero and at the period. A synchronisation unit lets an event reload the counter with a programmed phase value. An event comes either from an external sync pulse or from a software trigger, which is a change of level on a configuration bit. In up-down mode the reload also sets the counting direction.

The block also drives a sync output. Several timers can be chained through it so that they keep a fixed phase offset to each other. A two-bit selector picks its source: the incoming sync pulse, the zero indication, the period indication, or the software trigger. All configuration arrives as plain input levels, held by a register block outside this unit.

Top module: `pwm_phase_timer`

## Requirements
- R1: When `cfg_sync_en` is 0, neither `sync_in` nor a software trigger changes the counter, which keeps stepping in its current mode.
- R2: When `cfg_sync_en` is 1 and a sync event occurs at a rising clock edge, `cnt_value` equals `cfg_phase` after that edge. The reload replaces the normal count step, and counting continues from the phase value on the following edge.
- R3: Each change of level on `cfg_sw_sync`, 0 to 1 or 1 to 0, produces exactly one software sync event, one clock cycle long. A held level produces none.
- R4: `cfg_syncout_sel` picks the source of `sync_out`: 0 passes `sync_in` through whatever `cfg_sync_en` is, 1 gives `tez_pulse`, 2 gives `tep_pulse`, and 3 gives the software sync event.
- R5: With `cfg_mode` = 0 (count up), the counter adds one each cycle and returns to 0 on the cycle after it holds a value at or above `cfg_period`.
- R6: With `cfg_mode` = 1 (count down), the counter subtracts one each cycle and loads `cfg_period` on the cycle after it holds 0.
- R7: With `cfg_mode` = 2 or 3 (up-down), the counter turns to counting down after reaching `cfg_period` and turns to counting up after reaching 0. Each turning value is held for only one cycle.
- R8: In up-down mode a phase reload also sets the direction from `cfg_phase_down`: 0 counts up after the reload, 1 counts down.
- R9: `tez_pulse` is 1 exactly in the cycles when `cnt_value` is 0, and `tep_pulse` is 1 exactly in the cycles when `cnt_value` equals `cfg_period`.
- R10: A synchronous active-low reset sets the counter to 0, the direction to up, and the stored copy of the software bit to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_sync_en | input | 1 | Allows sync events to reload the counter |
| cfg_sw_sync | input | 1 | Software trigger bit; any change of level is an event |
| cfg_syncout_sel | input | 2 | Source of `sync_out` (0 input, 1 zero, 2 period, 3 software) |
| cfg_phase | input | 16 | Value loaded into the counter on a sync event |
| cfg_phase_down | input | 1 | Direction after a reload in up-down mode (1 = down) |
| cfg_period | input | 16 | Counter period |
| cfg_mode | input | 2 | 0 up, 1 down, 2 or 3 up-down |
| sync_in | input | 1 | External sync pulse, one cycle wide |
| cnt_value | output | 16 | Current counter value |
| tez_pulse | output | 1 | Counter holds zero |
| tep_pulse | output | 1 | Counter holds the period |
| sync_out | output | 1 | Selected sync source for neighbouring timers |

## Verification
The bench reloads the counter with chosen phases and counts a known number of steps into each wrap and turnaround. A design that skips the period value, holds a turnaround value for two cycles, or lets a normal count step win over a reload lands on a value off by one or more. The phase is also placed above the period, where a design that tests only for equality with the period would run past the wrap. Software triggers are tested on both edges of the bit, and the bench confirms that the trigger pulse is gone one cycle later; a design that only sees rising edges, or that leaves the event asserted, either misses the second reload or reloads again. Disabled reloads, each `sync_out` source, and the reset state of the counter are each checked at the ports.

// File: rtl/pwm_sync_pkg.sv
// Package: shared encodings for the PWM phase-synchronised time base.
// Assumes: mode and sync-out select arrive as 2-bit fields.
package pwm_sync_pkg;

    typedef enum logic [1:0] {
        MODE_UP      = 2'd0,
        MODE_DOWN    = 2'd1,
        MODE_UPDOWN  = 2'd2,
        MODE_UPDOWN2 = 2'd3
    } cnt_mode_e;

    typedef enum logic [1:0] {
        SO_SYNC_IN = 2'd0,
        SO_ZERO    = 2'd1,
        SO_PERIOD  = 2'd2,
        SO_SOFT    = 2'd3
    } syncout_sel_e;

    // Direction flag values used in up-down mode.
    localparam logic DIR_UP   = 1'b0;
    localparam logic DIR_DOWN = 1'b1;

endpackage

// File: rtl/pwm_soft_sync.sv
// Module: pwm_soft_sync
// Turns every change of level on a software trigger bit into a one-cycle event.
// Assumes: the trigger bit is synchronous to clk; the stored copy resets to 0.
module pwm_soft_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_bit,
    output logic soft_evt
);

    logic trig_q;

    // Keep the level of the trigger bit from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q <= 1'b0;
        end else begin
            trig_q <= trig_bit;
        end
    end

    // An event is any difference between the bit and its stored copy.
    always_comb begin
        soft_evt = trig_bit ^ trig_q;
    end

endmodule

// File: rtl/pwm_time_base.sv
// Module: pwm_time_base
// Counter with three counting modes and a phase reload that wins over the step.
// Assumes: reload_i is already qualified by the sync enable; the period is static
// while counting. In up-down mode the direction comes from the reload as well.
module pwm_time_base
    import pwm_sync_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] phase_i,
    input  logic             phase_down_i,
    input  logic             reload_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             at_zero_o,
    output logic             at_period_o
);

    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             dir_q;
    logic             dir_d;
    logic             updown;
    cnt_mode_e        mode;

    assign mode   = cnt_mode_e'(mode_i);
    assign updown = (mode == MODE_UPDOWN) || (mode == MODE_UPDOWN2);

    // Pick the next counter value and direction: reload first, then the mode step.
    always_comb begin
        cnt_d = cnt_q;
        dir_d = dir_q;
        if (reload_i) begin
            cnt_d = phase_i;
            if (updown) begin
                dir_d = phase_down_i;
            end
        end else begin
            case (mode)
                MODE_UP: begin
                    cnt_d = (cnt_q >= period_i) ? ZERO : cnt_q + ONE;
                end
                MODE_DOWN: begin
                    cnt_d = (cnt_q == ZERO) ? period_i : cnt_q - ONE;
                end
                default: begin
                    if (dir_q == DIR_UP) begin
                        if (cnt_q >= period_i) begin
                            dir_d = DIR_DOWN;
                            cnt_d = (cnt_q == ZERO) ? ZERO : cnt_q - ONE;
                        end else begin
                            cnt_d = cnt_q + ONE;
                        end
                    end else begin
                        if (cnt_q == ZERO) begin
                            dir_d = DIR_UP;
                            cnt_d = (period_i == ZERO) ? ZERO : ONE;
                        end else begin
                            cnt_d = cnt_q - ONE;
                        end
                    end
                end
            endcase
        end
    end

    // Register the counter and the up-down direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= ZERO;
            dir_q <= DIR_UP;
        end else begin
            cnt_q <= cnt_d;
            dir_q <= dir_d;
        end
    end

    // Indications taken from the registered counter value.
    always_comb begin
        cnt_o       = cnt_q;
        at_zero_o   = (cnt_q == ZERO);
        at_period_o = (cnt_q == period_i);
    end

endmodule

// File: rtl/pwm_syncout_mux.sv
// Module: pwm_syncout_mux
// Selects which event drives the sync output towards neighbouring timers.
// Assumes: all sources are single-cycle pulses in the same clock domain.
module pwm_syncout_mux
    import pwm_sync_pkg::*;
(
    input  logic [1:0] sel_i,
    input  logic       sync_in_i,
    input  logic       zero_i,
    input  logic       period_i,
    input  logic       soft_i,
    output logic       sync_out_o
);

    // Four-way selection of the outgoing sync source.
    always_comb begin
        case (syncout_sel_e'(sel_i))
            SO_SYNC_IN: sync_out_o = sync_in_i;
            SO_ZERO:    sync_out_o = zero_i;
            SO_PERIOD:  sync_out_o = period_i;
            default:    sync_out_o = soft_i;
        endcase
    end

endmodule

// File: rtl/pwm_phase_timer.sv
// Module: pwm_phase_timer
// PWM time base with phase reload from an external or software sync and a
// selectable sync output. Assumes: sync_in is a one-cycle pulse synchronous to clk,
// and configuration is held stable by an outside register block.
module pwm_phase_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_sync_en,
    input  logic             cfg_sw_sync,
    input  logic [1:0]       cfg_syncout_sel,
    input  logic [CNT_W-1:0] cfg_phase,
    input  logic             cfg_phase_down,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic [1:0]       cfg_mode,
    input  logic             sync_in,
    output logic [CNT_W-1:0] cnt_value,
    output logic             tez_pulse,
    output logic             tep_pulse,
    output logic             sync_out
);

    logic soft_evt;
    logic reload;

    pwm_soft_sync u_soft (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_bit (cfg_sw_sync),
        .soft_evt (soft_evt)
    );

    // A reload needs the enable and either sync source.
    always_comb begin
        reload = cfg_sync_en & (sync_in | soft_evt);
    end

    pwm_time_base #(.CNT_W(CNT_W)) u_base (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_i       (cfg_mode),
        .period_i     (cfg_period),
        .phase_i      (cfg_phase),
        .phase_down_i (cfg_phase_down),
        .reload_i     (reload),
        .cnt_o        (cnt_value),
        .at_zero_o    (tez_pulse),
        .at_period_o  (tep_pulse)
    );

    pwm_syncout_mux u_mux (
        .sel_i      (cfg_syncout_sel),
        .sync_in_i  (sync_in),
        .zero_i     (tez_pulse),
        .period_i   (tep_pulse),
        .soft_i     (soft_evt),
        .sync_out_o (sync_out)
    );

endmodule

// File: rtl/pwm_phase_timer_chk.sv
// Module: pwm_phase_timer_chk
// Property checks on the ports of pwm_phase_timer, attached by bind.
// Keeps its own copy of the software bit so it does not depend on design internals.
module pwm_phase_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_sync_en,
    input logic             cfg_sw_sync,
    input logic [1:0]       cfg_syncout_sel,
    input logic [CNT_W-1:0] cfg_phase,
    input logic [CNT_W-1:0] cfg_period,
    input logic [1:0]       cfg_mode,
    input logic             sync_in,
    input logic [CNT_W-1:0] cnt_value,
    input logic             tez_pulse,
    input logic             tep_pulse,
    input logic             sync_out
);

    logic sw_seen;
    logic sw_change;
    logic any_evt;

    // Shadow of the software trigger bit from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) sw_seen <= 1'b0;
        else        sw_seen <= cfg_sw_sync;
    end

    assign sw_change = cfg_sw_sync != sw_seen;
    assign any_evt   = sync_in || sw_change;

    AST_PHASE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sync_en && any_evt) |=> (cnt_value == $past(cfg_phase))); // R2

    AST_NO_LOAD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_sync_en && cfg_mode == 2'd0 && cnt_value < cfg_period)
        |=> (cnt_value == $past(cnt_value) + 1'b1)); // R1

    AST_SOFT_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_syncout_sel == 2'd3 && !sw_change) |-> !sync_out); // R3

    AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd0 && !(cfg_sync_en && any_evt) && cnt_value >= cfg_period)
        |=> (cnt_value == '0)); // R5

    AST_DOWN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd1 && !(cfg_sync_en && any_evt) && cnt_value == '0)
        |=> (cnt_value == $past(cfg_period))); // R6

    AST_FLAGS_APART: assert property (@(posedge clk) disable iff (!rst_n)
        (tez_pulse && cfg_period != '0) |-> !tep_pulse); // R9

    AST_RESET_ZERO: assert property (@(posedge clk)
        !rst_n |=> (cnt_value == '0)); // R10

endmodule

bind pwm_phase_timer pwm_phase_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_sync_en     (cfg_sync_en),
    .cfg_sw_sync     (cfg_sw_sync),
    .cfg_syncout_sel (cfg_syncout_sel),
    .cfg_phase       (cfg_phase),
    .cfg_period      (cfg_period),
    .cfg_mode        (cfg_mode),
    .sync_in         (sync_in),
    .cnt_value       (cnt_value),
    .tez_pulse       (tez_pulse),
    .tep_pulse       (tep_pulse),
    .sync_out        (sync_out)
);

// File: tb/pwm_phase_timer_test.sv
module pwm_phase_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_sync_en = 1'b0;
    logic        cfg_sw_sync = 1'b0;
    logic [1:0]  cfg_syncout_sel = 2'd0;
    logic [15:0] cfg_phase = '0;
    logic        cfg_phase_down = 1'b0;
    logic [15:0] cfg_period = '0;
    logic [1:0]  cfg_mode = 2'd0;
    logic        sync_in = 1'b0;
    logic [15:0] cnt_value;
    logic        tez_pulse;
    logic        tep_pulse;
    logic        sync_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    pwm_phase_timer uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_sync_en     (cfg_sync_en),
        .cfg_sw_sync     (cfg_sw_sync),
        .cfg_syncout_sel (cfg_syncout_sel),
        .cfg_phase       (cfg_phase),
        .cfg_phase_down  (cfg_phase_down),
        .cfg_period      (cfg_period),
        .cfg_mode        (cfg_mode),
        .sync_in         (sync_in),
        .cnt_value       (cnt_value),
        .tez_pulse       (tez_pulse),
        .tep_pulse       (tep_pulse),
        .sync_out        (sync_out)
    );

    // Vector table: mode, period, phase, direction bit, steps after reload, expected count.
    localparam int NV = 14;
    localparam int V_MODE [NV] = '{0, 0, 0, 0, 1, 1, 1, 2, 2, 3, 2, 2, 0, 2};
    localparam int V_PER  [NV] = '{10,10,10,10,10,10,10,10,10,10,10,10,10, 6};
    localparam int V_PH   [NV] = '{3, 3, 3, 3, 3, 3, 3, 8, 8, 8, 2, 2, 15, 6};
    localparam int V_DN   [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 0, 0};
    localparam int V_K    [NV] = '{0, 5, 8, 9, 3, 4, 6, 2, 4, 3, 2, 5, 1, 1};
    localparam int V_EXP  [NV] = '{3, 8, 0, 1, 0, 10, 8, 10, 8, 5, 0, 3, 0, 5};

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    // Reload through sync_in at the next edge; leave the bench at a falling edge.
    task automatic pulse_sync();
        sync_in = 1'b1;
        @(negedge clk);
        sync_in = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] c0;
        repeat (3) @(negedge clk);
        // R10: reset state with all configuration at zero.
        check("R10 count after reset", cnt_value, 0);
        check("R9 zero flag at reset", tez_pulse, 1);
        check("R4 sync_out follows idle sync_in", sync_out, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R2 R5 R6 R7 R8.
        for (int i = 0; i < NV; i++) begin
            cfg_mode       = V_MODE[i][1:0];
            cfg_period     = V_PER[i][15:0];
            cfg_phase      = V_PH[i][15:0];
            cfg_phase_down = V_DN[i][0];
            cfg_sync_en    = 1'b1;
            pulse_sync();
            for (int k = 0; k < V_K[i]; k++) @(negedge clk);
            check($sformatf("R2/R5/R6/R7/R8 vector %0d", i), cnt_value, V_EXP[i]);
        end

        // R1: disabled reloads leave the count stepping.
        cfg_mode = 2'd0; cfg_period = 16'd100; cfg_phase = 16'd10;
        pulse_sync();
        cfg_sync_en = 1'b0;
        cfg_phase = 16'd50;
        c0 = cnt_value;
        pulse_sync();
        check("R1 sync_in ignored when disabled", cnt_value, c0 + 1);
        cfg_sw_sync = ~cfg_sw_sync;
        @(negedge clk);
        check("R1 soft trigger ignored when disabled", cnt_value, c0 + 2);
        @(negedge clk);

        // R3/R4: soft trigger on both edges, one cycle each, seen on sync_out.
        cfg_sync_en = 1'b1; cfg_syncout_sel = 2'd3; cfg_phase = 16'd40;
        cfg_sw_sync = ~cfg_sw_sync;
        #1;
        check("R4 select 3 shows soft event", sync_out, 1);
        @(negedge clk);
        check("R3 reload on first toggle", cnt_value, 40);
        check("R3 soft event lasts one cycle", sync_out, 0);
        @(negedge clk);
        check("R3 no second reload while held", cnt_value, 41);
        cfg_sw_sync = ~cfg_sw_sync;
        @(negedge clk);
        check("R3 reload on opposite toggle", cnt_value, 40);

        // R9/R4: period and zero flags and their sync_out selections.
        cfg_period = 16'd5; cfg_phase = 16'd5; cfg_syncout_sel = 2'd2;
        pulse_sync();
        check("R9 period flag", tep_pulse, 1);
        check("R9 zero flag low at period", tez_pulse, 0);
        check("R4 select 2 shows period flag", sync_out, 1);
        @(negedge clk);
        check("R5 wrap to zero", cnt_value, 0);
        check("R9 zero flag", tez_pulse, 1);
        check("R9 period flag low at zero", tep_pulse, 0);
        cfg_syncout_sel = 2'd1;
        #1;
        check("R4 select 1 shows zero flag", sync_out, 1);

        // R4: select 0 passes sync_in even with reloads disabled.
        @(negedge clk);
        cfg_syncout_sel = 2'd0; cfg_sync_en = 1'b0; sync_in = 1'b1;
        #1;
        check("R4 select 0 passes sync_in", sync_out, 1);
        @(negedge clk);
        sync_in = 1'b0;

        // R10: reset in the middle of a run.
        cfg_period = 16'd100;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 reset mid-run", cnt_value, 0);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end

endmodule